// File: doc/BRIEF.md
# Pixel Region Readout with Token-Passed Column Bus

This block is the digital readout for a group of eight pixels inside a pixel column. Each pixel raises a ready flag and holds an 18-bit hit word. The region takes one ready pixel per cycle and stores its word, together with a 9-bit pixel address, in a four-entry FIFO. It tells that pixel its word was taken with a one-cycle acknowledge.

Many regions share one column bus. Access to the bus is set by a token that runs through a chain of regions. A region that receives the token and holds words puts one word on the bus per cycle. It keeps the token from the regions further down the chain until its FIFO is empty. The region also gives a combinational fast-OR of its pixels' ready flags, which trigger or monitoring logic can use.

Each region's bus outputs are zero when it is not driving, so the column bus can be a plain OR of all region outputs.

Top module: `pixel_region_readout`

## Requirements
- R1: After reset the FIFO is empty, `bus_valid` is low, `bus_word` is zero, and `token_out` follows `token_in`.
- R2: In a cycle where the FIFO is not full and any pixel is ready, the lowest-indexed ready pixel is captured. `hit_ack` is high for exactly that pixel, and no other pixel is captured in that cycle.
- R3: A bus word has 27 bits. Bits 26:21 hold `region_addr`, bits 20:18 hold the pixel index inside the region, and bits 17:0 hold that pixel's hit data.
- R4: Words leave a region in the order in which they were captured.
- R5: The FIFO holds 4 words. While it is full, no pixel is acknowledged. A stalled pixel keeps its flag and data and is captured once space frees.
- R6: `bus_valid` is high only when `token_in` is high and the FIFO holds a word. Each such cycle presents one word and removes it from the FIFO.
- R7: `token_out` is low while the region holds words, and equals `token_in` when the FIFO is empty.
- R8: `fast_or` is the OR of the region's eight `hit_valid` inputs.
- R9: In a chain of regions that are all loaded at once, no two regions drive in the same cycle. Every hit appears on the bus exactly once, ordered by chain position and then by pixel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_addr | input | 6 | Region number placed in the upper address bits |
| hit_valid | input | 8 | Per-pixel hit-ready flags |
| hit_data | input | 144 | Per-pixel 18-bit hit words, pixel i at bits 18i+17:18i |
| hit_ack | output | 8 | One-hot capture acknowledge to the pixels |
| token_in | input | 1 | Bus grant from the region upstream |
| token_out | output | 1 | Bus grant passed to the region downstream |
| bus_valid | output | 1 | This region drives a word this cycle |
| bus_word | output | 27 | Address and data word, zero when not driving |
| fast_or | output | 1 | OR of all pixel ready flags |

## Verification
The bench loads all eight pixels of one region while the token is withheld. A design that fills the FIFO in the wrong order, or acknowledges a pixel while full, shows a wrong acknowledge pattern or loses the stalled pixels' data. When the token is then granted, a design that drives without the token, leaks the token while still holding words, or reorders entries produces words out of sequence or a downstream token too early. A sweep of many hit masks over a four-region chain compares every bus word against the expected sequence by region and pixel. That catches a wrong field layout, two regions driving at once, and duplicated or dropped hits.

// File: rtl/pixel_region_readout.sv
module pixel_region_readout #(
  parameter int NPIX   = 8,
  parameter int DATA_W = 18,
  parameter int ID_W   = 9,
  parameter int DEPTH  = 4,
  localparam int PIX_W  = $clog2(NPIX),
  localparam int REG_W  = ID_W - PIX_W,
  localparam int WORD_W = ID_W + DATA_W,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_W-1:0]       region_addr,
  input  logic [NPIX-1:0]        hit_valid,
  input  logic [NPIX*DATA_W-1:0] hit_data,
  output logic [NPIX-1:0]        hit_ack,
  input  logic                   token_in,
  output logic                   token_out,
  output logic                   bus_valid,
  output logic [WORD_W-1:0]      bus_word,
  output logic                   fast_or
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W:0]    count;
  logic [PIX_W-1:0]  sel;
  logic              push, pop;

  always_comb begin
    sel = '0;
    for (int i = NPIX - 1; i >= 0; i--)
      if (hit_valid[i]) sel = PIX_W'(i);
  end

  assign fast_or   = |hit_valid;
  assign push      = fast_or && (count < (PTR_W+1)'(DEPTH));
  assign pop       = token_in && (count != '0);
  assign hit_ack   = push ? (NPIX'(1) << sel) : '0;
  assign bus_valid = pop;
  assign bus_word  = pop ? mem[rd_ptr] : '0;
  assign token_out = token_in && (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {region_addr, sel, hit_data[sel*DATA_W +: DATA_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PTR_W+1)'(DEPTH)); // R5
  AST_COUNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (count > $past(count)) |-> $past(hit_ack != '0)); // R5
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_ack)); // R2
  AST_ACK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ack != '0) |-> (((hit_ack - 1'b1) & hit_valid) == '0) && ((hit_ack & hit_valid) != '0)); // R2
  AST_BUS_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> token_in); // R6
  AST_TOKEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !token_out); // R7
  AST_FAST_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ack != '0) |-> fast_or); // R8

endmodule

// File: tb/test_pixel_region_readout.sv
module test_pixel_region_readout;
  localparam int NREG = 4;
  localparam int NPIX = 8;
  localparam int DW   = 18;
  localparam int WW   = 27;

  logic clk = 0;
  logic rst_n = 0;
  logic head_tok = 0;
  logic [NREG*NPIX-1:0]    valid = '0;
  logic [NREG*NPIX*DW-1:0] data = '0;
  logic [NREG*NPIX-1:0]    ack;
  logic [NREG:0]           tok;
  logic [NREG-1:0]         bv, fo;
  logic [WW-1:0]           bw [NREG];
  logic [WW-1:0]           bus;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign tok[0] = head_tok;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_top
      pixel_region_readout i_pixel_region_readout (
        .clk(clk), .rst_n(rst_n), .region_addr(6'(r)),
        .hit_valid(valid[r*NPIX +: NPIX]), .hit_data(data[r*NPIX*DW +: NPIX*DW]),
        .hit_ack(ack[r*NPIX +: NPIX]), .token_in(tok[r]), .token_out(tok[r+1]),
        .bus_valid(bv[r]), .bus_word(bw[r]), .fast_or(fo[r]));
    end else begin : g_other
      pixel_region_readout u_reg (
        .clk(clk), .rst_n(rst_n), .region_addr(6'(r)),
        .hit_valid(valid[r*NPIX +: NPIX]), .hit_data(data[r*NPIX*DW +: NPIX*DW]),
        .hit_ack(ack[r*NPIX +: NPIX]), .token_in(tok[r]), .token_out(tok[r+1]),
        .bus_valid(bv[r]), .bus_word(bw[r]), .fast_or(fo[r]));
    end
  end

  always_comb begin
    bus = '0;
    for (int r = 0; r < NREG; r++) bus = bus | bw[r];
  end

  function automatic logic [DW-1:0] dfun(int p, int r, int i);
    return DW'(p * 1031 + r * 131 + i * 17 + 5);
  endfunction

  function automatic logic [WW-1:0] wfun(int p, int r, int i);
    return {6'(r), 3'(i), dfun(p, r, i)};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_and_release;
    logic [NREG*NPIX-1:0] a;
    a = ack;
    @(posedge clk);
    #1 valid = valid & ~a;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] expw [64];
    logic [15:0] lfsr;
    int nexp, got;
    logic [7:0] mask;

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(bv == '0 && bus == '0, "R1 bus idle after reset", bv, 0);
    check(tok[NREG] == 1'b0, "R1 token follows low input", tok[NREG], 0);
    head_tok = 1;
    #1 check(tok[NREG] == 1'b1, "R1 token passes empty chain", tok[NREG], 1);
    check(fo == '0, "R8 fast_or idle", fo, 0);
    head_tok = 0;
    @(posedge clk); #1;

    for (int i = 0; i < NPIX; i++) data[i*DW +: DW] = dfun(99, 0, i);
    valid[NPIX-1:0] = '1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(ack[NPIX-1:0] == (k < 4 ? 8'(1 << k) : 8'h0), "R2/R5 ack order and stall", ack[NPIX-1:0], k < 4 ? (1 << k) : 0);
      check(bv[0] == 1'b0, "R6 no drive without token", bv[0], 0);
      check(fo[0] == 1'b1, "R8 fast_or with pending hits", fo[0], 1);
      edge_and_release();
    end
    check(valid[NPIX-1:0] == 8'hF0, "R5 stalled pixels keep flags", valid[NPIX-1:0], 8'hF0);
    head_tok = 1;
    got = 0;
    for (int c = 0; c < 40 && got < NPIX; c++) begin
      @(negedge clk);
      if (got < NPIX) check(tok[NREG] == 1'b0, "R7 token held while draining", tok[NREG], 0);
      if (bv[0]) begin
        check(bus == wfun(99, 0, got), "R3/R4 directed word", bus, wfun(99, 0, got));
        got++;
      end
      edge_and_release();
    end
    check(got == NPIX, "R5 all stalled hits delivered", got, NPIX);
    @(negedge clk);
    check(tok[NREG] == 1'b1 && bv == '0, "R7 token released when empty", tok[NREG], 1);
    @(posedge clk); #1;

    lfsr = 16'hACE1;
    for (int p = 0; p < 40; p++) begin
      nexp = 0;
      for (int r = 0; r < NREG; r++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mask = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : lfsr[7:0];
        for (int i = 0; i < NPIX; i++) begin
          valid[r*NPIX + i] = mask[i];
          data[(r*NPIX + i)*DW +: DW] = dfun(p, r, i);
          if (mask[i]) begin expw[nexp] = wfun(p, r, i); nexp++; end
        end
      end
      got = 0;
      for (int c = 0; c < 200 && (got < nexp || c == 0); c++) begin
        @(negedge clk);
        if (c == 0)
          for (int r = 0; r < NREG; r++)
            check(fo[r] == (valid[r*NPIX +: NPIX] != 0), "R8 fast_or per region", fo[r], valid[r*NPIX +: NPIX] != 0);
        if ($countones(bv) > 1) check(0, "R9 single driver", bv, 0);
        if (bv != '0) begin
          if (got < nexp) check(bus == expw[got], "R9 chain order word", bus, expw[got]);
          else check(0, "R9 extra word", bus, 0);
          got++;
        end
        edge_and_release();
      end
      check(got == nexp, "R9 word count", got, nexp);
      @(negedge clk);
      check(bv == '0 && tok[NREG] == 1'b1, "R7 chain idle after drain", {bv, tok[NREG]}, 1);
      @(posedge clk); #1;
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule